// File: doc/BRIEF.md
# Grouped Input Debounce Filter

This block cleans up a bank of digital input lines before the rest of the chip sees them. Each line has a filtered copy that follows the raw line only after the raw level has stayed at a new value, without a break, for a selectable time. Time is counted in pulses of a tick input that the surrounding logic generates at a fixed rate. The parameter `UNITS_PER_MS` gives the number of ticks per millisecond, so the default of 1000 corresponds to a 1 µs tick.

The lines come in two kinds. The first 12 lines form a base bank. It is split into four groups, and each group shares one 4-bit time code from a 16-bit base configuration word. Every further bank of 16 lines has its own 8-bit time code, and these codes are packed two per 16-bit configuration word. The first four lines also carry a 4-bit mode code each. Certain mode values route the raw line straight to the output and skip the filter.

A time code selects the filter time from a table. The table starts at a short 0.8 ms step and then doubles from 1 ms up to 128 ms. Codes beyond the table fall back to the shortest time.

Top module: `grp_debounce`

## Requirements
- R1: A filtered line takes the raw level on the L-th tick, counted at rising clock edges, after the raw level first differs from the filtered value, where L is the selected length in ticks. Until that tick it keeps its previous value. Both rising and falling changes behave the same way.
- R2: Time code 0 gives L = UNITS_PER_MS*4/5 ticks (0.8 ms). Code n, for n from 1 to 8, gives L = UNITS_PER_MS * 2^(n-1) ticks (1, 2, 4, 8, 16, 32, 64 and 128 ms).
- R3: On any clock cycle where the raw level equals the filtered value, the run count is cleared. A glitch back to the old level therefore restarts the full L-tick wait.
- R4: The base word `cfg_base_i` holds four codes. Bits [3:0] serve lines 0–2, bits [7:4] serve lines 3–4, bits [11:8] serve lines 5–6, and bits [15:12] serve lines 7–11.
- R5: Extension bank k (lines 12+16k to 27+16k) takes its code from `cfg_ext_i[8k+7:8k]`. Even banks use the low byte of a 16-bit word and odd banks use the high byte.
- R6: A code above 8 (a nibble of 9–F, or a byte of 9–255) selects the 0.8 ms length.
- R7: Lines 0–3 each have a mode nibble `mode_i[4i+3:4i]`. When that nibble is 1 or 2, `filt_o[i]` equals `raw_i[i]` in the same cycle. Any other value (0, 3–F) leaves the line filtered.
- R8: The run count advances only on clock cycles where `tick_i` is high. With `tick_i` held low, no filtered line changes.
- R9: While `rst_ni` is low, every filtered line is 0 and every run count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base pulse, UNITS_PER_MS per millisecond |
| raw_i | input | 12+16*NUM_EXT | Raw input lines, already in the clk_i domain |
| mode_i | input | 16 | Mode nibble for each of lines 0–3 |
| cfg_base_i | input | 16 | Four 4-bit time codes for the base groups |
| cfg_ext_i | input | 8*NUM_EXT | One 8-bit time code per extension bank |
| filt_o | output | 12+16*NUM_EXT | Filtered lines |

## Verification
Suppose a raw line changes just after rising edge c while ticks arrive every cycle. Its filtered output must still show the old level after edge c+L-1 and the new level after edge c+L. A line in bypass must show the new level before edge c+1. The bench records the drive cycle of each stimulus. It files each expectation in the scoreboard under the exact cycle derived from the requirements and compares at the falling edge of that cycle. This pins each result to one cycle, so a result one tick early or one tick late is reported. During the tick-gating case the bench adds the idle cycles to the due cycle.

// File: rtl/dbnc_pkg.sv
package dbnc_pkg;
  localparam int BASE_LINES  = 12;
  localparam int BASE_GROUPS = 4;
  localparam int EXT_LINES   = 16;
  localparam int CODE_W      = 8;
  localparam int MODE_W      = 4;
  localparam int BYP_LINES   = 4;
  localparam int MAX_CODE    = 8;

  // base bank grouping: 0-2, 3-4, 5-6, 7-11
  function automatic int base_group(input int line);
    if (line < 3)      return 0;
    else if (line < 5) return 1;
    else if (line < 7) return 2;
    else               return 3;
  endfunction

  function automatic logic mode_bypass(input logic [MODE_W-1:0] m);
    return (m == 4'd1) || (m == 4'd2);
  endfunction
endpackage

// File: rtl/dbnc_span_lut.sv
module dbnc_span_lut import dbnc_pkg::*; #(
  parameter int UNITS_PER_MS = 1000,
  parameter int CNT_W        = 17
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [CNT_W-1:0]  limit_o
);
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'((UNITS_PER_MS * 4) / 5);
  localparam logic [CNT_W-1:0] ONE_MS  = CNT_W'(UNITS_PER_MS);
  localparam logic [CNT_W-1:0] MAX_LIM = CNT_W'(UNITS_PER_MS * 128);

  always_comb begin
    limit_o = MIN_LIM;
    if (code_i >= 8'd1 && code_i <= 8'(MAX_CODE))
      limit_o = ONE_MS << (code_i - 8'd1);
  end

  always_comb begin
    assert_span_bounds_R2: assert (limit_o >= MIN_LIM && limit_o <= MAX_LIM);
  end
endmodule

// File: rtl/dbnc_cell.sv
module dbnc_cell #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             filt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
    end else if (raw_i == filt_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q >= limit_i - 1'b1) begin
        filt_q <= raw_i;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = filt_q;

  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_i == filt_q) |=> $stable(filt_q));

  assert_tick_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(filt_q));

  assert_no_early_flip_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && raw_i != filt_q && (cnt_q + 1'b1) < limit_i) |=> $stable(filt_q));
endmodule

// File: rtl/grp_debounce.sv
module grp_debounce import dbnc_pkg::*; #(
  parameter int  NUM_EXT      = 2,
  parameter int  UNITS_PER_MS = 1000,
  localparam int NUM_LINES    = BASE_LINES + EXT_LINES * NUM_EXT,
  localparam int CNT_W        = $clog2(128 * UNITS_PER_MS + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        tick_i,
  input  logic [NUM_LINES-1:0]        raw_i,
  input  logic [MODE_W*BYP_LINES-1:0] mode_i,
  input  logic [15:0]                 cfg_base_i,
  input  logic [CODE_W*NUM_EXT-1:0]   cfg_ext_i,
  output logic [NUM_LINES-1:0]        filt_o
);
  logic [CNT_W-1:0] base_lim [BASE_GROUPS];
  logic [CNT_W-1:0] ext_lim  [NUM_EXT];

  // one decoder per shared field, not per line
  for (genvar g = 0; g < BASE_GROUPS; g++) begin : g_base_lut
    dbnc_span_lut #(.UNITS_PER_MS(UNITS_PER_MS), .CNT_W(CNT_W)) u_lut (
      .code_i ({4'b0000, cfg_base_i[4*g +: 4]}),
      .limit_o(base_lim[g])
    );
  end

  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext_lut
    dbnc_span_lut #(.UNITS_PER_MS(UNITS_PER_MS), .CNT_W(CNT_W)) u_lut (
      .code_i (cfg_ext_i[CODE_W*e +: CODE_W]),
      .limit_o(ext_lim[e])
    );
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [CNT_W-1:0] lim;
    logic             filt;

    if (i < BASE_LINES) begin : g_bsel
      assign lim = base_lim[base_group(i)];
    end else begin : g_esel
      assign lim = ext_lim[(i - BASE_LINES) / EXT_LINES];
    end

    dbnc_cell #(.CNT_W(CNT_W)) u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .raw_i  (raw_i[i]),
      .limit_i(lim),
      .filt_o (filt)
    );

    if (i < BYP_LINES) begin : g_byp
      assign filt_o[i] = mode_bypass(mode_i[MODE_W*i +: MODE_W]) ? raw_i[i] : filt;
    end else begin : g_nobyp
      assign filt_o[i] = filt;
    end
  end
endmodule

// File: tb/grp_debounce_bench.sv
module grp_debounce_bench;
  localparam int NUM_EXT = 2;
  localparam int UPM     = 10;
  localparam int NL      = 12 + 16 * NUM_EXT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b1;
  logic [NL-1:0] raw = '0;
  logic [15:0]   mode = '0;
  logic [15:0]   cfg_base = 16'h2130;
  logic [15:0]   cfg_ext = {8'd5, 8'd8};
  logic [NL-1:0] filt;

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  int    q_due[$];
  int    q_line[$];
  bit    q_val[$];
  string q_req[$];

  grp_debounce #(.NUM_EXT(NUM_EXT), .UNITS_PER_MS(UPM)) u_grp_debounce (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .raw_i(raw), .mode_i(mode),
    .cfg_base_i(cfg_base), .cfg_ext_i(cfg_ext), .filt_o(filt)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int line, input bit act, input bit exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s line %0d cycle %0d: got %0b expected %0b", req, line, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input int line, input bit val, input string req);
    int idx = q_due.size();
    for (int k = 0; k < q_due.size(); k++) begin
      if (q_due[k] > due) begin idx = k; break; end
    end
    q_due.insert(idx, due);
    q_line.insert(idx, line);
    q_val.insert(idx, val);
    q_req.insert(idx, req);
  endtask

  // expect old level through c+L-1, new level from c+L
  task automatic expect_run(input int c, input int line, input bit nv, input int len, input string req);
    push(c + len - 1, line, !nv, req);
    push(c + len, line, nv, req);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q_due.size() != 0) @(negedge clk);
    step();
  endtask

  // monitor
  always @(negedge clk) begin
    while (q_due.size() != 0 && q_due[0] <= cyc) begin
      if (q_due[0] < cyc) begin
        n_vec++; n_bad++;
        $display("FAIL %s line %0d: check due %0d missed at %0d", q_req[0], q_line[0], q_due[0], cyc);
      end else begin
        chk(q_req[0], q_line[0], filt[q_line[0]], q_val[0]);
      end
      void'(q_due.pop_front()); void'(q_line.pop_front());
      void'(q_val.pop_front()); void'(q_req.pop_front());
    end
  end

  initial begin
    #200;
    @(negedge clk);
    // R9: outputs held at 0 during reset
    for (int i = 0; i < NL; i++) chk("R9", i, filt[i], 1'b0);
    rst_n = 1'b1;
    step();
    raw[0] = 1'b1;
    for (int i = 0; i < NL; i++) chk("R9", i, filt[i], 1'b0);

    // R1 R2: line 0, code 0 -> 8 ticks, rise
    expect_run(cyc, 0, 1'b1, 8, "R1");
    drain();
    raw[0] = 1'b0;
    expect_run(cyc, 0, 1'b0, 8, "R2");
    drain();

    // R4: lines 3 and 4 share code 3 -> 40 ticks
    raw[3] = 1'b1; raw[4] = 1'b1;
    expect_run(cyc, 3, 1'b1, 40, "R4");
    expect_run(cyc, 4, 1'b1, 40, "R4");
    drain();

    // R4: lines 9 and 11 code 2 -> 20; line 5 code 1 -> 10
    raw[9] = 1'b1; raw[11] = 1'b1; raw[5] = 1'b1;
    expect_run(cyc, 9, 1'b1, 20, "R4");
    expect_run(cyc, 11, 1'b1, 20, "R4");
    expect_run(cyc, 5, 1'b1, 10, "R2");
    drain();

    // R3: glitch on line 6 restarts the wait
    raw[6] = 1'b1;
    for (int k = 0; k < 6; k++) step();
    raw[6] = 1'b0;
    step();
    chk("R3", 6, filt[6], 1'b0);
    raw[6] = 1'b1;
    expect_run(cyc, 6, 1'b1, 10, "R3");
    drain();

    // R5: bank 0 code 8 -> 1280, bank 1 code 5 -> 160
    raw[12] = 1'b1; raw[27] = 1'b1; raw[28] = 1'b1; raw[43] = 1'b1;
    expect_run(cyc, 28, 1'b1, 160, "R5");
    expect_run(cyc, 43, 1'b1, 160, "R5");
    expect_run(cyc, 12, 1'b1, 1280, "R5");
    expect_run(cyc, 27, 1'b1, 1280, "R5");
    drain();

    // R6: out-of-range codes act as code 0 (8 ticks)
    cfg_base = 16'h2139;
    cfg_ext = {8'hC8, 8'd8};
    step();
    raw[1] = 1'b1; raw[30] = 1'b1;
    expect_run(cyc, 1, 1'b1, 8, "R6");
    expect_run(cyc, 30, 1'b1, 8, "R6");
    drain();

    // R7: mode 1 on line 0, 2 on line 2, 3 on line 3 (filtered)
    mode = 16'h3201;
    step();
    raw[0] = 1'b1; raw[2] = 1'b1; raw[3] = 1'b0;
    push(cyc, 0, 1'b1, "R7");
    push(cyc, 2, 1'b1, "R7");
    expect_run(cyc, 3, 1'b0, 40, "R7");
    step();
    raw[2] = 1'b0;
    push(cyc, 2, 1'b0, "R7");
    drain();

    // R8: no progress without ticks
    tick = 1'b0;
    raw[5] = 1'b0;
    push(cyc + 5, 5, 1'b1, "R8");
    push(cyc + 29, 5, 1'b1, "R8");
    drain();
    for (int k = 0; k < 10; k++) step();
    tick = 1'b1;
    expect_run(cyc, 5, 1'b0, 10, "R8");
    drain();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule